// File: doc/BRIEF.md
# Wrong-Path Cache Fill Classifier

This block watches a set-associative cache from the side and sorts the fills that speculative execution brings in. Each line carries a pending mark and the tag of the branch that issued the fill. The line is not judged until that branch resolves. A mispredicted branch turns its pending lines into wrong-path lines. A correctly predicted branch returns them to ordinary lines. Each wrong-path line is judged once: it is Used if a correct-path hit reaches it first, and Unused if a later fill replaces it first.

Two further classes track harm done to correct-path work. A speculative fill may displace a victim. Its address goes into a small FIFO, and it is armed once the branch is known to be mispredicted. A correct-path miss on an armed address counts as a Direct Miss. A speculative hit that only reorders a set's replacement order marks that set. Once its branch is known to be mispredicted, the next correct-path miss in that set that is not a Direct Miss counts as an Indirect Miss. Four saturating counters hold the class totals and are read through a select input.

Top module: `wpfill_classifier`

## Requirements
- R1: After reset all four counters read zero.
- R2: A line filled speculatively whose branch then resolves as mispredicted adds one to Used at its first correct-path hit. Later hits add nothing.
- R3: A wrong-path line that is replaced by any fill before a correct-path hit adds one to Unused.
- R4: A speculative fill whose branch resolves as correctly predicted is never classified. Its victim address is dropped, so a miss on that address adds nothing to Direct Miss.
- R5: A correct-path hit on a line whose branch is still unresolved adds nothing. The line can still be counted as Used after a mispredict resolution.
- R6: A correct-path miss whose address equals an armed victim address adds one to Direct Miss and consumes that entry. A repeated miss on the same address adds nothing.
- R7: A speculative hit followed by a mispredict resolution of its tag marks its set. The next correct-path miss in that set that is not a Direct Miss adds one to Indirect Miss and clears the mark.
- R8: A resolution acts only on lines, victim entries and set marks whose stored tag equals the resolved tag.
- R9: Each counter stops at 2^CNT_W-1 and never wraps.
- R10: The victim FIFO holds VB_DEPTH entries. When it is full, a new victim overwrites the oldest entry, and the overwritten address no longer yields a Direct Miss.
- R11: rd_data shows the counter chosen by rd_sel in the same cycle: 0 Used, 1 Unused, 2 Direct Miss, 3 Indirect Miss.
- R12: A speculative hit never classifies a line, even when the line is wrong-path.
- R13: At most one of fill_v, hit_v, miss_v and res_v is high in a cycle. Events on consecutive cycles are each applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_v | input | 1 | Fill event |
| fill_set | input | $clog2(SETS) | Set of the fill |
| fill_way | input | $clog2(WAYS) | Way of the fill |
| fill_spec | input | 1 | Fill issued by an unresolved speculative reference |
| fill_tag | input | TAG_W | Branch tag of a speculative fill |
| fill_vic_v | input | 1 | Fill displaced a valid victim |
| fill_vic_addr | input | ADDR_W | Victim line address |
| hit_v | input | 1 | Hit event, which also updates the replacement order |
| hit_set | input | $clog2(SETS) | Set of the hit |
| hit_way | input | $clog2(WAYS) | Way of the hit |
| hit_spec | input | 1 | Hit from an unresolved speculative reference |
| hit_tag | input | TAG_W | Branch tag of a speculative hit |
| miss_v | input | 1 | Correct-path load miss |
| miss_set | input | $clog2(SETS) | Set of the miss |
| miss_addr | input | ADDR_W | Line address of the miss |
| res_v | input | 1 | Branch resolution event |
| res_tag | input | TAG_W | Tag of the resolved branch |
| res_bad | input | 1 | 1 = mispredicted, 0 = correctly predicted |
| rd_sel | input | 2 | Counter select |
| rd_data | output | CNT_W | Selected counter value |

## Verification
The Used and Unused paths are each swept over every set and way of a small configuration. This shows that the line index is built correctly from set and way, and that a line is classified only once. Mixed sequences set correct resolutions, unresolved hits, speculative hits and unrelated tags against mispredicted ones. This separates classification driven by tag match and resolution outcome from classification driven only by timing. Victim sequences overfill the FIFO to separate the newest, the overwritten and the consumed entries. A long run of Used events shows the counter stopping at its ceiling.

// File: rtl/wpfc_pkg.sv
package wpfc_pkg;
   typedef enum logic [1:0] {
      CLS_USED     = 2'd0,
      CLS_UNUSED   = 2'd1,
      CLS_DIRECT   = 2'd2,
      CLS_INDIRECT = 2'd3
   } wpfc_class_e;
   localparam int NUM_CLS = 4;
endpackage

// File: rtl/wpfc_sat_ctr.sv
module wpfc_sat_ctr #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   if (W < 2) begin : g_chk
      $error("wpfc_sat_ctr: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)               q <= '0;
      else if (inc && q != TOP) q <= q + 1'b1;
   end

   a_r9_hold_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      (q == TOP) |=> (q == TOP));
   a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && q != TOP) |=> (q == $past(q) + 1'b1));
endmodule

// File: rtl/wpfc_line_tbl.sv
module wpfc_line_tbl #(
   parameter int SETS  = 8,
   parameter int WAYS  = 4,
   parameter int TAG_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fill_v,
   input  logic [$clog2(SETS)-1:0]  fill_set,
   input  logic [$clog2(WAYS)-1:0]  fill_way,
   input  logic                     fill_spec,
   input  logic [TAG_W-1:0]         fill_tag,
   input  logic                     chit_v,
   input  logic [$clog2(SETS)-1:0]  hit_set,
   input  logic [$clog2(WAYS)-1:0]  hit_way,
   input  logic                     res_v,
   input  logic [TAG_W-1:0]         res_tag,
   input  logic                     res_bad,
   output logic                     used_o,
   output logic                     unused_o
);
   localparam int LINES = SETS * WAYS;

   logic [LINES-1:0] spec_q, wp_q;
   logic [TAG_W-1:0] tag_q [LINES];
   int fill_idx, hit_idx;

   always_comb begin
      fill_idx = int'(fill_set) * WAYS + int'(fill_way);
      hit_idx  = int'(hit_set) * WAYS + int'(hit_way);
   end

   assign used_o   = chit_v && (hit_idx < LINES) && wp_q[hit_idx];
   assign unused_o = fill_v && (fill_idx < LINES) && wp_q[fill_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         spec_q <= '0;
         wp_q   <= '0;
         for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
      end else begin
         for (int i = 0; i < LINES; i++) begin
            if (fill_v && fill_idx == i) begin
               spec_q[i] <= fill_spec;
               wp_q[i]   <= 1'b0;
               tag_q[i]  <= fill_tag;
            end else if (chit_v && hit_idx == i) begin
               wp_q[i] <= 1'b0;
            end else if (res_v && spec_q[i] && tag_q[i] == res_tag) begin
               spec_q[i] <= 1'b0;
               wp_q[i]   <= res_bad;
            end
         end
      end
   end

   a_r5_pending_not_wrongpath: assert property (@(posedge clk) disable iff (!rst_n)
      (spec_q & wp_q) == '0);
   a_r2_classified_once: assert property (@(posedge clk) disable iff (!rst_n)
      used_o |=> !wp_q[$past(hit_idx)]);
endmodule

// File: rtl/wpfc_victim_buf.sv
module wpfc_victim_buf #(
   parameter int DEPTH  = 8,
   parameter int TAG_W  = 4,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_v,
   input  logic [TAG_W-1:0]  push_tag,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              res_v,
   input  logic [TAG_W-1:0]  res_tag,
   input  logic              res_bad,
   input  logic              look_v,
   input  logic [ADDR_W-1:0] look_addr,
   output logic              hit_o
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 1) begin : g_chk
      $error("wpfc_victim_buf: DEPTH must be at least 1");
   end

   logic [DEPTH-1:0]  valid_q, armed_q, match;
   logic [TAG_W-1:0]  tag_q  [DEPTH];
   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [PTR_W-1:0]  wr_ptr;

   always_comb begin
      for (int i = 0; i < DEPTH; i++)
         match[i] = valid_q[i] && armed_q[i] && addr_q[i] == look_addr;
   end
   assign hit_o = look_v && |match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         armed_q <= '0;
         wr_ptr  <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            tag_q[i]  <= '0;
            addr_q[i] <= '0;
         end
      end else begin
         if (push_v) begin
            valid_q[wr_ptr] <= 1'b1;
            armed_q[wr_ptr] <= 1'b0;
            tag_q[wr_ptr]   <= push_tag;
            addr_q[wr_ptr]  <= push_addr;
            wr_ptr <= (int'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + 1'b1;
         end
         for (int i = 0; i < DEPTH; i++) begin
            if (res_v && valid_q[i] && !armed_q[i] && tag_q[i] == res_tag) begin
               if (res_bad) armed_q[i] <= 1'b1;
               else         valid_q[i] <= 1'b0;
            end
            if (look_v && match[i]) valid_q[i] <= 1'b0;
         end
      end
   end

   a_r6_entry_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> ($countones(valid_q & armed_q) < $past($countones(valid_q & armed_q))));
endmodule

// File: rtl/wpfill_classifier.sv
module wpfill_classifier
   import wpfc_pkg::*;
#(
   parameter int SETS     = 8,
   parameter int WAYS     = 4,
   parameter int TAG_W    = 4,
   parameter int ADDR_W   = 32,
   parameter int VB_DEPTH = 8,
   parameter int CNT_W    = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fill_v,
   input  logic [$clog2(SETS)-1:0]  fill_set,
   input  logic [$clog2(WAYS)-1:0]  fill_way,
   input  logic                     fill_spec,
   input  logic [TAG_W-1:0]         fill_tag,
   input  logic                     fill_vic_v,
   input  logic [ADDR_W-1:0]        fill_vic_addr,
   input  logic                     hit_v,
   input  logic [$clog2(SETS)-1:0]  hit_set,
   input  logic [$clog2(WAYS)-1:0]  hit_way,
   input  logic                     hit_spec,
   input  logic [TAG_W-1:0]         hit_tag,
   input  logic                     miss_v,
   input  logic [$clog2(SETS)-1:0]  miss_set,
   input  logic [ADDR_W-1:0]        miss_addr,
   input  logic                     res_v,
   input  logic [TAG_W-1:0]         res_tag,
   input  logic                     res_bad,
   input  logic [1:0]               rd_sel,
   output logic [CNT_W-1:0]         rd_data
);
   if (SETS < 2 || WAYS < 2) begin : g_chk_geom
      $error("wpfill_classifier: SETS and WAYS must be at least 2");
   end
   if (TAG_W < 1 || ADDR_W < 1) begin : g_chk_w
      $error("wpfill_classifier: TAG_W and ADDR_W must be positive");
   end

   logic used, unused, direct, indirect;
   logic [NUM_CLS-1:0] cls_inc;
   logic [CNT_W-1:0]   cnt_q [NUM_CLS];

   logic [SETS-1:0]  lru_pend_q, lru_wp_q;
   logic [TAG_W-1:0] lru_tag_q [SETS];

   wpfc_line_tbl #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_lines (
      .clk, .rst_n,
      .fill_v, .fill_set, .fill_way, .fill_spec, .fill_tag,
      .chit_v  (hit_v && !hit_spec),
      .hit_set, .hit_way,
      .res_v, .res_tag, .res_bad,
      .used_o  (used),
      .unused_o(unused)
   );

   wpfc_victim_buf #(.DEPTH(VB_DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_vbuf (
      .clk, .rst_n,
      .push_v   (fill_v && fill_spec && fill_vic_v),
      .push_tag (fill_tag),
      .push_addr(fill_vic_addr),
      .res_v, .res_tag, .res_bad,
      .look_v   (miss_v),
      .look_addr(miss_addr),
      .hit_o    (direct)
   );

   assign indirect = miss_v && !direct && lru_wp_q[miss_set];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lru_pend_q <= '0;
         lru_wp_q   <= '0;
         for (int s = 0; s < SETS; s++) lru_tag_q[s] <= '0;
      end else begin
         for (int s = 0; s < SETS; s++) begin
            if (hit_v && hit_spec && int'(hit_set) == s) begin
               lru_pend_q[s] <= 1'b1;
               lru_tag_q[s]  <= hit_tag;
            end else if (res_v && lru_pend_q[s] && lru_tag_q[s] == res_tag) begin
               lru_pend_q[s] <= 1'b0;
               lru_wp_q[s]   <= lru_wp_q[s] | res_bad;
            end else if (indirect && int'(miss_set) == s) begin
               lru_wp_q[s] <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      cls_inc               = '0;
      cls_inc[CLS_USED]     = used;
      cls_inc[CLS_UNUSED]   = unused;
      cls_inc[CLS_DIRECT]   = direct;
      cls_inc[CLS_INDIRECT] = indirect;
   end

   for (genvar g = 0; g < NUM_CLS; g++) begin : g_cnt
      wpfc_sat_ctr #(.W(CNT_W)) u_ctr (
         .clk, .rst_n, .inc(cls_inc[g]), .q(cnt_q[g])
      );
   end

   assign rd_data = cnt_q[rd_sel];

   a_r13_one_event: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fill_v, hit_v, miss_v, res_v}));
   a_r7_mark_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      indirect |=> !lru_wp_q[$past(miss_set)]);
   a_r7_direct_first: assert property (@(posedge clk) disable iff (!rst_n)
      direct |-> !indirect);
endmodule

// File: tb/wpfill_classifier_tb.sv
module wpfill_classifier_tb;
   localparam int SETS = 4, WAYS = 2, TAG_W = 4, ADDR_W = 12, VB = 4, CW = 6;
   localparam int TOP = (1 << CW) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic fill_v = 0, fill_spec = 0, fill_vic_v = 0, hit_v = 0, hit_spec = 0;
   logic miss_v = 0, res_v = 0, res_bad = 0;
   logic [1:0] fill_set = 0, hit_set = 0, miss_set = 0;
   logic       fill_way = 0, hit_way = 0;
   logic [TAG_W-1:0] fill_tag = 0, hit_tag = 0, res_tag = 0;
   logic [ADDR_W-1:0] fill_vic_addr = 0, miss_addr = 0;
   logic [1:0] rd_sel = 0;
   logic [CW-1:0] rd_data;

   int total = 0, bad = 0;
   int e_used = 0, e_unused = 0, e_direct = 0, e_ind = 0;
   bit done = 0;

   wpfill_classifier #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .ADDR_W(ADDR_W),
                       .VB_DEPTH(VB), .CNT_W(CW)) u_dut (.*);

   task automatic chk(input int sel, input int exp, input string req);
      rd_sel = 2'(sel);
      #1;
      total++;
      if (int'(rd_data) != exp) begin
         bad++;
         $display("FAIL %s: counter %0d actual=%0d expected=%0d", req, sel, rd_data, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk(0, e_used, req); chk(1, e_unused, req);
      chk(2, e_direct, req); chk(3, e_ind, req);
   endtask

   task automatic fill(input int s, input int w, input bit sp, input int tg,
                       input bit vv, input int va);
      fill_v = 1; fill_set = 2'(s); fill_way = 1'(w); fill_spec = sp;
      fill_tag = 4'(tg); fill_vic_v = vv; fill_vic_addr = 12'(va);
      @(negedge clk); fill_v = 0; fill_vic_v = 0;
   endtask

   task automatic hit(input int s, input int w, input bit sp, input int tg);
      hit_v = 1; hit_set = 2'(s); hit_way = 1'(w); hit_spec = sp; hit_tag = 4'(tg);
      @(negedge clk); hit_v = 0;
   endtask

   task automatic miss(input int s, input int a);
      miss_v = 1; miss_set = 2'(s); miss_addr = 12'(a);
      @(negedge clk); miss_v = 0;
   endtask

   task automatic res(input int tg, input bit b);
      res_v = 1; res_tag = 4'(tg); res_bad = b;
      @(negedge clk); res_v = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk_all("R1 R11 reset");

      // R2 R13: used sweep over all lines, back-to-back events
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin
            fill(s, w, 1, 1, 0, 0); res(1, 1); hit(s, w, 0, 0);
            e_used++;
            chk(0, e_used, "R2 R13 used sweep");
         end
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) hit(s, w, 0, 0);
      chk(0, e_used, "R2 second hit adds nothing");

      // R3: unused sweep
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin
            fill(s, w, 1, 2, 0, 0); res(2, 1); fill(s, w, 0, 0, 0, 0);
            e_unused++;
            chk(1, e_unused, "R3 unused sweep");
         end
      chk(0, e_used, "R3 used untouched");

      // R4: correct resolution
      fill(0, 0, 1, 3, 1, 'h111); res(3, 0); hit(0, 0, 0, 0);
      fill(0, 0, 0, 0, 0, 0); miss(0, 'h111);
      chk_all("R4 correct resolution");

      // R5: hit before resolve
      fill(1, 0, 1, 4, 0, 0); hit(1, 0, 0, 0);
      chk(0, e_used, "R5 unresolved hit ignored");
      res(4, 1); hit(1, 0, 0, 0); e_used++;
      chk(0, e_used, "R5 used after resolve");

      // R12: speculative hit never classifies
      fill(1, 1, 1, 5, 0, 0); res(5, 1); hit(1, 1, 1, 6);
      chk(0, e_used, "R12 spec hit ignored");
      res(6, 0); hit(1, 1, 0, 0); e_used++;
      chk(0, e_used, "R12 later correct hit");
      miss(1, 'h7AA);
      chk(3, e_ind, "R8 good-resolved set mark"); chk(2, e_direct, "R6 unrelated miss");

      // R6: direct miss
      fill(2, 0, 1, 7, 1, 'h222); miss(2, 'h222);
      chk(2, e_direct, "R6 unarmed victim");
      res(7, 1); miss(2, 'h222); e_direct++;
      chk(2, e_direct, "R6 direct miss");
      miss(2, 'h222); miss(2, 'h333);
      chk(2, e_direct, "R6 consumed once");

      // R7: indirect miss
      hit(3, 0, 1, 8); res(8, 1); miss(3, 'h444); e_ind++;
      chk(3, e_ind, "R7 indirect miss");
      miss(3, 'h445);
      chk(3, e_ind, "R7 mark cleared");

      // R8: tag selectivity
      fill(0, 1, 1, 9, 0, 0); fill(3, 1, 1, 10, 0, 0); res(9, 1);
      hit(3, 1, 0, 0);
      chk(0, e_used, "R8 other tag untouched");
      hit(0, 1, 0, 0); e_used++;
      chk(0, e_used, "R8 matching tag");
      res(10, 0); hit(3, 1, 0, 0);
      chk(0, e_used, "R8 good resolve");

      // R10: FIFO overwrite
      for (int k = 0; k < VB + 1; k++) fill(3, k % 2, 1, 11, 1, 'hA00 + k);
      res(11, 1);
      miss(3, 'hA00);
      chk(2, e_direct, "R10 oldest overwritten");
      chk(3, e_ind, "R10 no indirect");
      miss(3, 'hA00 + VB); e_direct++;
      chk(2, e_direct, "R10 newest kept");
      miss(3, 'hA01); e_direct++;
      chk(2, e_direct, "R10 second oldest kept");
      fill(3, 0, 0, 0, 0, 0); fill(3, 1, 0, 0, 0, 0); e_unused += 2;
      chk(1, e_unused, "R3 after victim traffic");

      // R9: saturation
      for (int i = 0; i < 60; i++) begin
         fill(0, 0, 1, 12, 0, 0); res(12, 1); hit(0, 0, 0, 0);
         e_used = (e_used < TOP) ? e_used + 1 : TOP;
         chk(0, e_used, "R9 saturation");
      end
      chk_all("R9 R11 final");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule